// File: doc/BRIEF.md
# Bit Interleave Unit

This unit performs a perfect shuffle of bits and its inverse. In the interleave operation, two words are merged bit by bit into one word of twice the width. The first operand supplies the more significant bit of every pair. The de-interleave operation splits a double-width word back into its odd-position bits and its even-position bits. Two reduced operations are also provided. Spread interleaves a word with zeros. Gather keeps only the odd-position bits.

Both a full-width mode and a half-width mode exist. In full-width mode, two 32-bit words give a 64-bit result. In half-width mode, two 16-bit halves give a 32-bit result. A typical use is changing the number of bits per pixel of raster data by a power of two. For example, a 1-bit-per-pixel word can be interleaved with zero, all-ones or itself to give 2-bit pixel codes, and the de-interleave operation runs the conversion the other way.

Each operation is accepted on a cycle with `in_valid` high. Its result appears in registers on the next clock edge, with `out_valid` high.

Top module: `bitzip`

## Requirements
- R1: While reset is asserted, and after its release until the first accepted operation, `out_valid` is 0 and both result words are 0.
- R2: `out_valid` is high exactly in the cycle after a cycle with `in_valid` high. When `in_valid` is low, both result words keep their previous values.
- R3: Opcode 2'b00 with `half`=0 is the full interleave. Result bit 2i+1 is `opa[i]` and result bit 2i is `opb[i]`, for i from 0 to W-1. The result is `{res_hi,res_lo}`, so the MSB of the result is `opa[W-1]`.
- R4: Opcode 2'b01 with `half`=0 de-interleaves the word X=`{opa,opb}`. `res_hi[i]` is X[2i+1] and `res_lo[i]` is X[2i].
- R5: Opcode 2'b10 (spread) gives the same result as opcode 2'b00 with `opb` taken as zero, in either mode. The value on `opb` has no effect on the result.
- R6: Opcode 2'b11 (gather) with `half`=0 puts the odd-position bits of `{opa,opb}` in `res_hi` and sets `res_lo` to 0.
- R7: With `half`=1, interleave and spread take only `opa[W/2-1:0]` and `opb[W/2-1:0]`. They place the W-bit interleave in `res_lo` with the same bit ordering as R3, and `res_hi` is 0. In half-width mode, `res_hi` is 0 for every opcode.
- R8: With `half`=1, opcode 2'b01 de-interleaves `opb`. The odd-position bits go to `res_lo[W-1:W/2]` and the even-position bits go to `res_lo[W/2-1:0]`. Opcode 2'b11 gives the same upper half, with `res_lo[W/2-1:0]` equal to 0.
- R9: Feeding the de-interleave outputs back into the interleave returns the original word exactly. In full-width mode, `res_hi` is used as `opa` and `res_lo` as `opb`. In half-width mode, the upper and lower halves of `res_lo` are used as `opa` and `opb`.
- R10: Seen as 1-bit pixels, the interleaves map pixel values to 2-bit codes as follows. X with 0 maps 0 to 00 and 1 to 10. 0 with X maps 1 to 01. X with all-ones maps 0 to 01 and 1 to 11. X with X maps 0 to 00 and 1 to 11.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Asynchronous reset, active low |
| in_valid | input | 1 | Operation request for this cycle |
| op | input | 2 | 00 interleave, 01 de-interleave, 10 spread, 11 gather |
| half | input | 1 | 1 selects half-width mode |
| opa | input | W | First operand; upper word of a double-width source |
| opb | input | W | Second operand; lower word of a double-width source |
| res_hi | output | W | Upper result word (registered) |
| res_lo | output | W | Lower result word (registered) |
| out_valid | output | 1 | Result words were updated on the last edge |

## Verification
The hardest behaviour to reach from the ports is the round trip in half-width mode. The de-interleave output must be split into its two halves and driven back as operands, while the unused upper operand bits carry noise that must not leak into the result. The bench does this with back-to-back operations that reuse the captured result, and it fills all ignored operand bits with random values. Random operations are interleaved with idle cycles, so that the hold behaviour after every opcode and mode is also observed.

// File: rtl/bitzip.sv
module bitzip #(
  parameter int W = 32
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         in_valid,
  input  logic [1:0]   op,
  input  logic         half,
  input  logic [W-1:0] opa,
  input  logic [W-1:0] opb,
  output logic [W-1:0] res_hi,
  output logic [W-1:0] res_lo,
  output logic         out_valid
);
  localparam int HW = W / 2;
  localparam int DW = 2 * W;

  localparam logic [1:0] OP_ZIP   = 2'b00;
  localparam logic [1:0] OP_UNZIP = 2'b01;
  localparam logic [1:0] OP_SPRD  = 2'b10;
  localparam logic [1:0] OP_GATH  = 2'b11;

  logic [W-1:0]  b_eff;
  logic [DW-1:0] src;
  logic [DW-1:0] zip_full;
  logic [W-1:0]  zip_half;
  logic [W-1:0]  odd_full, even_full;
  logic [HW-1:0] odd_half, even_half;
  logic [W-1:0]  nxt_hi, nxt_lo;

  assign b_eff = (op == OP_SPRD) ? '0 : opb;
  assign src   = {opa, opb};

  for (genvar i = 0; i < W; i++) begin : g_full
    assign zip_full[2*i+1] = opa[i];
    assign zip_full[2*i]   = b_eff[i];
    assign odd_full[i]     = src[2*i+1];
    assign even_full[i]    = src[2*i];
  end

  for (genvar i = 0; i < HW; i++) begin : g_half
    assign zip_half[2*i+1] = opa[i];
    assign zip_half[2*i]   = b_eff[i];
    assign odd_half[i]     = opb[2*i+1];
    assign even_half[i]    = opb[2*i];
  end

  always_comb begin
    nxt_hi = '0;
    nxt_lo = '0;
    if (half) begin
      unique case (op)
        OP_ZIP, OP_SPRD: nxt_lo = zip_half;
        OP_UNZIP:        nxt_lo = {odd_half, even_half};
        OP_GATH:         nxt_lo = {odd_half, {HW{1'b0}}};
      endcase
    end else begin
      unique case (op)
        OP_ZIP, OP_SPRD: {nxt_hi, nxt_lo} = zip_full;
        OP_UNZIP:        {nxt_hi, nxt_lo} = {odd_full, even_full};
        OP_GATH:         nxt_hi = odd_full;
      endcase
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      res_hi    <= '0;
      res_lo    <= '0;
      out_valid <= 1'b0;
    end else begin
      out_valid <= in_valid;
      if (in_valid) begin
        res_hi <= nxt_hi;
        res_lo <= nxt_lo;
      end
    end
  end
endmodule

// File: rtl/bitzip_chk.sv
module bitzip_chk #(
  parameter int W = 32
) (
  input logic         clk,
  input logic         rst_n,
  input logic         in_valid,
  input logic [1:0]   op,
  input logic         half,
  input logic [W-1:0] opa,
  input logic [W-1:0] opb,
  input logic [W-1:0] res_hi,
  input logic [W-1:0] res_lo,
  input logic         out_valid
);
  always_comb begin
    if (!rst_n) begin
      assert_reset_clear_R1: assert (!out_valid && res_hi == '0 && res_lo == '0);
    end
  end

  assert_valid_follows_R2: assert property (@(posedge clk) disable iff (!rst_n)
    out_valid == $past(in_valid));

  assert_hold_idle_R2: assert property (@(posedge clk) disable iff (!rst_n)
    !$past(in_valid) |-> ($stable(res_hi) && $stable(res_lo)));

  assert_zip_ends_R3: assert property (@(posedge clk) disable iff (!rst_n)
    $past(in_valid && op == 2'b00 && !half) |->
      (res_hi[W-1] == $past(opa[W-1]) && res_lo[0] == $past(opb[0])));

  assert_spread_even_zero_R5: assert property (@(posedge clk) disable iff (!rst_n)
    $past(in_valid && op == 2'b10) |-> (res_lo[0] == 1'b0 && res_lo[2] == 1'b0));

  assert_gather_lo_zero_R6: assert property (@(posedge clk) disable iff (!rst_n)
    $past(in_valid && op == 2'b11 && !half) |-> res_lo == '0);

  assert_half_hi_zero_R7: assert property (@(posedge clk) disable iff (!rst_n)
    $past(in_valid && half) |-> res_hi == '0);
endmodule

bind bitzip bitzip_chk #(.W(W)) u_chk (.*);

// File: tb/bitzip_tb.sv
`timescale 1ns/1ps
module bitzip_tb;
  localparam int W  = 32;
  localparam int HW = W / 2;

  logic         clk = 1'b0;
  logic         rst_n = 1'b0;
  logic         in_valid = 1'b0;
  logic [1:0]   op = 2'b00;
  logic         half = 1'b0;
  logic [W-1:0] opa = '0;
  logic [W-1:0] opb = '0;
  logic [W-1:0] res_hi, res_lo;
  logic         out_valid;

  int n_tests = 0;
  int n_fail  = 0;

  always #10 clk = ~clk;

  bitzip #(.W(W)) u_dut (
    .clk(clk), .rst_n(rst_n), .in_valid(in_valid), .op(op), .half(half),
    .opa(opa), .opb(opb), .res_hi(res_hi), .res_lo(res_lo), .out_valid(out_valid)
  );

  function automatic logic [2*W-1:0] ref_model(input logic [1:0] o, input logic h,
                                               input logic [W-1:0] a, input logic [W-1:0] b);
    logic [2*W-1:0] r;
    logic [2*W-1:0] x;
    r = '0;
    x = {a, b};
    if (o == 2'b10) b = '0;
    if (!h) begin
      for (int i = 0; i < W; i++) begin
        if (o == 2'b00 || o == 2'b10) begin
          r[2*i+1] = a[i];
          r[2*i]   = b[i];
        end else begin
          r[W+i] = x[2*i+1];
          if (o == 2'b01) r[i] = x[2*i];
        end
      end
    end else begin
      for (int i = 0; i < HW; i++) begin
        if (o == 2'b00 || o == 2'b10) begin
          r[2*i+1] = a[i];
          r[2*i]   = b[i];
        end else begin
          r[HW+i] = x[2*i+1];
          if (o == 2'b01) r[i] = x[2*i];
        end
      end
    end
    return r;
  endfunction

  function automatic logic [2*W-1:0] pixmap(input logic [W-1:0] x,
                                            input logic [1:0] c0, input logic [1:0] c1);
    logic [2*W-1:0] r;
    for (int i = 0; i < W; i++) r[2*i +: 2] = x[i] ? c1 : c0;
    return r;
  endfunction

  task automatic chk(input string req, input logic [2*W-1:0] act, input logic [2*W-1:0] exp);
    n_tests++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s: actual %h expected %h", req, act, exp);
    end
  endtask

  task automatic run_op(input logic [1:0] o, input logic h,
                        input logic [W-1:0] a, input logic [W-1:0] b);
    @(negedge clk);
    op = o; half = h; opa = a; opb = b; in_valid = 1'b1;
    @(negedge clk);
    in_valid = 1'b0;
  endtask

  initial begin
    repeat (2000) @(posedge clk);
    n_fail++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
    $finish;
  end

  initial begin
    logic [2*W-1:0] e;
    logic [W-1:0]   x, sh, sl;
    void'($urandom(32'h5eed_1234));

    repeat (3) @(negedge clk);
    chk("R1 reset", {res_hi, res_lo, 63'd0, out_valid}, '0);
    rst_n = 1'b1;
    @(negedge clk);
    chk("R1 after release", {res_hi, res_lo, 63'd0, out_valid}, '0);

    run_op(2'b00, 1'b0, 32'h8000_0000, 32'h0000_0001);
    chk("R3 zip ends", {res_hi, res_lo}, 64'h8000_0000_0000_0001);
    chk("R2 valid", {63'd0, out_valid}, 64'd1);
    @(negedge clk);
    chk("R2 valid drop", {63'd0, out_valid}, 64'd0);

    run_op(2'b00, 1'b0, 32'hFFFF_FFFF, 32'h0);
    chk("R3 zip a ones", {res_hi, res_lo}, {32{2'b10}});

    x = 32'hC3A5_0F71;
    run_op(2'b00, 1'b0, x, 32'h0);
    chk("R10 X zip 0", {res_hi, res_lo}, pixmap(x, 2'b00, 2'b10));
    run_op(2'b00, 1'b0, 32'h0, x);
    chk("R10 0 zip X", {res_hi, res_lo}, pixmap(x, 2'b00, 2'b01));
    run_op(2'b00, 1'b0, x, 32'hFFFF_FFFF);
    chk("R10 X zip ones", {res_hi, res_lo}, pixmap(x, 2'b01, 2'b11));
    run_op(2'b00, 1'b0, x, x);
    chk("R10 X zip X", {res_hi, res_lo}, pixmap(x, 2'b00, 2'b11));

    run_op(2'b10, 1'b0, x, 32'hDEAD_BEEF);
    chk("R5 spread ignores opb", {res_hi, res_lo}, pixmap(x, 2'b00, 2'b10));

    run_op(2'b01, 1'b0, 32'hAAAA_AAAA, 32'hAAAA_AAAA);
    chk("R4 unzip odd", {res_hi, res_lo}, {32'hFFFF_FFFF, 32'h0});
    run_op(2'b11, 1'b0, 32'h5555_5555, 32'hFFFF_FFFF);
    chk("R6 gather", {res_hi, res_lo}, {32'h0000_FFFF, 32'h0});

    run_op(2'b00, 1'b1, 32'h1234_FFFF, 32'h5678_0000);
    chk("R7 half zip", {res_hi, res_lo}, {32'h0, 32'hAAAA_AAAA});
    run_op(2'b01, 1'b1, 32'h9999_9999, 32'hAAAA_5555);
    chk("R8 half unzip", {res_hi, res_lo}, {32'h0, 32'hFF00_00FF});
    run_op(2'b11, 1'b1, 32'h9999_9999, 32'hAAAA_5555);
    chk("R8 half gather", {res_hi, res_lo}, {32'h0, 32'hFF00_0000});

    e = {res_hi, res_lo};
    @(negedge clk);
    op = 2'b00; opa = $urandom; opb = $urandom;
    @(negedge clk);
    chk("R2 hold", {res_hi, res_lo}, e);

    for (int k = 0; k < 40; k++) begin
      logic [W-1:0] ra, rb;
      ra = $urandom; rb = $urandom;
      run_op(2'b01, 1'b0, ra, rb);
      sh = res_hi; sl = res_lo;
      run_op(2'b00, 1'b0, sh, sl);
      chk("R9 full round trip", {res_hi, res_lo}, {ra, rb});
      run_op(2'b01, 1'b1, $urandom, rb);
      sl = res_lo;
      run_op(2'b00, 1'b1, {$urandom_range(65535), sl[W-1:HW]}[W-1:0],
             {16'($urandom), sl[HW-1:0]});
      chk("R9 half round trip", {res_hi, res_lo}, {32'h0, rb});
    end

    for (int k = 0; k < 300; k++) begin
      logic [1:0]   ro;
      logic         rh;
      logic [W-1:0] ra, rb;
      ro = 2'($urandom); rh = 1'($urandom); ra = $urandom; rb = $urandom;
      run_op(ro, rh, ra, rb);
      chk("R3 R4 R5 R6 R7 R8 random", {res_hi, res_lo}, ref_model(ro, rh, ra, rb));
      if ((k % 7) == 0) begin
        e = {res_hi, res_lo};
        @(negedge clk);
        chk("R2 idle hold", {res_hi, res_lo, 63'd0, out_valid}, {e, 64'd0});
      end
    end

    $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
    $finish;
  end
endmodule